// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

This block gathers interrupt requests from a set of peripheral lines and from four system-exception lines. Each request is held in a software-visible pending register. The block presents the most urgent eligible request to a processor as a vector index. A rising edge on any input line latches a pending bit. Each peripheral source carries a 2-bit field that either disables it or gives it priority level 1, 2 or 3. A global enable bit gates the peripheral sources and the watchdog timeout. The illegal-instruction trap and the two oscillator-failure exceptions ignore the global enable.

The processor watches `irq_valid` and `irq_vec`. When it takes a vector, it pulses `irq_ack` for one cycle, and this clears exactly the pending bit behind that vector. Software reaches four registers through a small register port. A write either loads a register with the data or ANDs the register with the data as a mask. On the pending registers, both kinds of write keep any bit that a new request sets in the same cycle, so a clear done as one AND write never loses an arriving request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all pending bits, priority fields and the global enable are 0, and `irq_valid` is 0.
- R2: A 0-to-1 transition on `periph_irq[i]` sets pending bit i, and a transition on `sys_exc[k]` sets system bit k. A line held high latches only once, so a bit cleared while its line stays high stays clear.
- R3: With `reg_wr`=1 and `reg_and`=0, the addressed register is loaded from `reg_wdata`. On the pending registers a 0 clears a bit and a 1 sets it.
- R4: With `reg_wr`=1 and `reg_and`=1, the addressed register becomes its old value ANDed with `reg_wdata`.
- R5: `irq_ack` while `irq_valid`=1 clears only the pending bit of the vector presented in that cycle. `irq_ack` while `irq_valid`=0 changes nothing.
- R6: If a new request and a clear (by write, AND or acknowledge) hit the same bit in one cycle, the bit ends up set.
- R7: Vector numbering is as follows. Vector 0 is the illegal-instruction trap (`sys_exc[0]`), vector 1 is watchdog oscillator failure (`sys_exc[1]`), vector 2 is primary oscillator failure (`sys_exc[2]`), vector 3 is watchdog timeout (`sys_exc[3]`), and vector 4+i is peripheral i. Pending vectors 0..2 win in ascending order, then vector 3, then peripherals.
- R8: Pending vectors 0..2 are presented regardless of the global enable.
- R9: With the global enable at 0, neither the watchdog timeout nor any peripheral produces `irq_valid`, although their bits still latch.
- R10: Among eligible peripherals, a higher level always wins over a lower one, and within a level the lower index wins. The field for source i is bits [2i+1:2i] of the register at address 1, where 00 means disabled (not presented), 01 is level 1, 10 is level 2 and 11 is level 3.
- R11: Register addresses are 0 for peripheral pending bits, 1 for priority fields, 2 for the system pending bits [3:0] and 3 for control, whose bit 0 is the global enable. `reg_rdata` shows the addressed register zero-extended in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq | input | N_SRC | Peripheral request lines |
| sys_exc | input | 4 | System exception lines |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_and | input | 1 | Write is AND-with-mask when 1 |
| reg_wdata | input | 2*N_SRC | Write data or mask |
| reg_rdata | output | 2*N_SRC | Read data of the addressed register |
| irq_valid | output | 1 | An eligible request is pending |
| irq_vec | output | clog2(N_SRC+4) | Vector index of the winning request |
| irq_ack | input | 1 | One-cycle acknowledge of the presented vector |

## Verification
Several requests are made pending at once with mixed levels, so the acknowledge sequence shows the order by level and, within a level, by index. A bad comparison or a reversed scan would change that order. Held-high lines, acknowledges and AND clears are made to land in the same cycle as new edges on the same bit. This separates set-wins behaviour and true edge detection from level latching or clear-wins logic. The global enable is toggled while system exceptions and peripherals are pending, which shows whether the enable gates exactly the watchdog and the peripherals and leaves the three non-maskable exceptions alone.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC = 8,
  localparam int NSYS = 4,
  localparam int DW = 2 * N_SRC,
  localparam int VW = $clog2(N_SRC + NSYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] periph_irq,
  input  logic [NSYS-1:0]  sys_exc,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_and,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq_valid,
  output logic [VW-1:0]    irq_vec,
  input  logic             irq_ack
);

  logic [N_SRC-1:0] pend_q, prev_p, pend_d;
  logic [NSYS-1:0]  sys_q, prev_s, sys_d;
  logic [DW-1:0]    prio_q;
  logic             gie_q;

  wire [N_SRC-1:0] rise_p = periph_irq & ~prev_p;
  wire [NSYS-1:0]  rise_s = sys_exc & ~prev_s;
  wire wr_p = reg_wr && reg_addr == 2'd0;
  wire wr_r = reg_wr && reg_addr == 2'd1;
  wire wr_s = reg_wr && reg_addr == 2'd2;
  wire wr_c = reg_wr && reg_addr == 2'd3;
  wire ack_hit = irq_ack && irq_valid;

  always_comb begin
    pend_d = pend_q;
    sys_d  = sys_q;
    if (wr_p) pend_d = reg_and ? (pend_q & reg_wdata[N_SRC-1:0]) : reg_wdata[N_SRC-1:0];
    if (wr_s) sys_d  = reg_and ? (sys_q & reg_wdata[NSYS-1:0]) : reg_wdata[NSYS-1:0];
    for (int i = 0; i < N_SRC; i++)
      if (ack_hit && irq_vec == VW'(i + NSYS)) pend_d[i] = 1'b0;
    for (int k = 0; k < NSYS; k++)
      if (ack_hit && irq_vec == VW'(k)) sys_d[k] = 1'b0;
    pend_d = pend_d | rise_p;
    sys_d  = sys_d | rise_s;
  end

  always_comb begin
    irq_valid = 1'b0;
    irq_vec   = '0;
    for (int lvl = 1; lvl <= 3; lvl++)
      for (int i = N_SRC - 1; i >= 0; i--)
        if (pend_q[i] && gie_q && prio_q[2*i +: 2] == 2'(lvl)) begin
          irq_valid = 1'b1;
          irq_vec   = VW'(i + NSYS);
        end
    if (sys_q[3] && gie_q) begin
      irq_valid = 1'b1;
      irq_vec   = VW'(3);
    end
    for (int k = 2; k >= 0; k--)
      if (sys_q[k]) begin
        irq_valid = 1'b1;
        irq_vec   = VW'(k);
      end
  end

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = DW'(pend_q);
      2'd1:    reg_rdata = prio_q;
      2'd2:    reg_rdata = DW'(sys_q);
      default: reg_rdata = DW'(gie_q);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= '0;
      prev_p <= '0;
      sys_q  <= '0;
      prev_s <= '0;
      prio_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      prev_p <= periph_irq;
      sys_q  <= sys_d;
      prev_s <= sys_exc;
      if (wr_r) prio_q <= reg_and ? (prio_q & reg_wdata) : reg_wdata;
      if (wr_c) gie_q  <= reg_and ? (gie_q & reg_wdata[0]) : reg_wdata[0];
    end

endmodule

module irq_prio_ctrl_chk #(
  parameter int N_SRC = 8,
  localparam int VW = $clog2(N_SRC + 4)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] periph_irq,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] prev_p,
  input logic [3:0]       sys_q,
  input logic             gie_q,
  input logic             irq_valid,
  input logic [VW-1:0]    irq_vec,
  input logic             irq_ack,
  input logic             reg_wr
);

  wire [N_SRC-1:0] edges = periph_irq & ~prev_p;

  a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    edges != '0 |=> (pend_q & $past(edges)) == $past(edges));

  a_r8_nmi_presented: assert property (@(posedge clk) disable iff (!rst_n)
    sys_q[2:0] != 3'b0 |-> irq_valid && irq_vec < VW'(3));

  a_r9_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q && sys_q[2:0] == 3'b0 |-> !irq_valid);

  a_r7_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
    sys_q[0] |-> irq_vec == '0);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && irq_valid && irq_vec >= VW'(4) && periph_irq == '0 && !reg_wr
    |=> !pend_q[$past(irq_vec) - VW'(4)]);

  a_r10_vec_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_vec >= VW'(4) |-> pend_q[irq_vec - VW'(4)] && gie_q);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq), .pend_q(pend_q),
  .prev_p(prev_p), .sys_q(sys_q), .gie_q(gie_q), .irq_valid(irq_valid),
  .irq_vec(irq_vec), .irq_ack(irq_ack), .reg_wr(reg_wr));

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int N = 8;
  localparam int DW = 2 * N;
  localparam int VW = $clog2(N + 4);

  logic clk = 0, rst_n = 0;
  logic [N-1:0] periph_irq = '0;
  logic [3:0] sys_exc = '0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 0, reg_and = 0, irq_ack = 0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_valid;
  logic [VW-1:0] irq_vec;

  irq_prio_ctrl #(.N_SRC(N)) i_irq_prio_ctrl (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  logic [N-1:0] m_pend = '0, m_prevp = '0;
  logic [3:0] m_sys = '0, m_prevs = '0;
  logic [DW-1:0] m_prio = '0;
  logic m_gie = 0;

  function automatic void model_out(output logic v, output int vec);
    int best = -1, bl = 0;
    v = 0; vec = 0;
    for (int i = 0; i < N; i++) begin
      int l = int'(m_prio[2*i +: 2]);
      if (m_pend[i] && m_gie && l > bl) begin best = i; bl = l; end
    end
    if (best >= 0) begin v = 1; vec = best + 4; end
    if (m_sys[3] && m_gie) begin v = 1; vec = 3; end
    for (int k = 2; k >= 0; k--) if (m_sys[k]) begin v = 1; vec = k; end
  endfunction

  function automatic logic [DW-1:0] model_rd();
    case (reg_addr)
      2'd0: return DW'(m_pend);
      2'd1: return m_prio;
      2'd2: return DW'(m_sys);
      default: return DW'(m_gie);
    endcase
  endfunction

  task automatic compare();
    logic v; int vec;
    model_out(v, vec);
    checks++;
    if (irq_valid !== v || (v && int'(irq_vec) != vec) || reg_rdata !== model_rd()) begin
      fails++;
      $display("FAIL %s: valid/vec/rdata %0b/%0d/%h expected %0b/%0d/%h",
               cur_req, irq_valid, irq_vec, reg_rdata, v, vec, model_rd());
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk);
      if (rst_n) begin
        logic v; int vec;
        model_out(v, vec);
        if (reg_wr) case (reg_addr)
          2'd0: m_pend = reg_and ? (m_pend & reg_wdata[N-1:0]) : reg_wdata[N-1:0];
          2'd1: m_prio = reg_and ? (m_prio & reg_wdata) : reg_wdata;
          2'd2: m_sys = reg_and ? (m_sys & reg_wdata[3:0]) : reg_wdata[3:0];
          default: m_gie = reg_and ? (m_gie & reg_wdata[0]) : reg_wdata[0];
        endcase
        if (irq_ack && v) begin
          if (vec < 4) m_sys[vec] = 0; else m_pend[vec-4] = 0;
        end
        m_pend |= periph_irq & ~m_prevp;
        m_sys |= sys_exc & ~m_prevs;
        m_prevp = periph_irq;
        m_prevs = sys_exc;
      end
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d, logic andop = 0);
    reg_addr = a; reg_wdata = d; reg_wr = 1; reg_and = andop;
    cyc();
    reg_wr = 0; reg_and = 0;
  endtask

  task automatic ack();
    irq_ack = 1; cyc(); irq_ack = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); compare();
    @(negedge clk); rst_n = 1; compare();
    cyc(2);

    cur_req = "R11"; reg_addr = 2'd1; cyc(); reg_addr = 2'd3; cyc();
    cur_req = "R10"; wr(2'd1, 16'b11_01_10_00_11_01_10_01);
    cur_req = "R11"; wr(2'd3, 16'h1);

    cur_req = "R2"; reg_addr = 2'd0;
    periph_irq[3] = 1; cyc(3);
    wr(2'd0, 16'h0); cyc(3);
    periph_irq[3] = 0; cyc();

    cur_req = "R10";
    periph_irq = 8'b1010_0111; cyc(); periph_irq = '0; cyc();
    for (int j = 0; j < 6; j++) begin ack(); cyc(); end
    cur_req = "R5"; ack(); cyc();

    cur_req = "R3"; wr(2'd0, 16'h00F0); cyc(); wr(2'd0, 16'h0030); cyc();
    cur_req = "R4";
    periph_irq[1] = 1; wr(2'd0, 16'h0020, 1); periph_irq[1] = 0; cyc(2);
    wr(2'd1, 16'hFF0F, 1); cyc();

    cur_req = "R6";
    periph_irq = '0; cyc();
    periph_irq[1] = 1; ack(); cyc();
    periph_irq = '0; cyc(); ack(); ack(); cyc();
    periph_irq[6] = 1; wr(2'd0, 16'h0, 1); periph_irq = '0; cyc();

    cur_req = "R9"; wr(2'd3, 16'h0); reg_addr = 2'd0;
    periph_irq = 8'h0F; sys_exc[3] = 1; cyc(2); periph_irq = '0; sys_exc = '0; cyc();
    cur_req = "R8"; reg_addr = 2'd2;
    sys_exc = 4'b0110; cyc(); sys_exc = '0; cyc();
    ack(); ack(); cyc();
    cur_req = "R7";
    sys_exc = 4'b0101; cyc(); sys_exc = '0; cyc();
    wr(2'd3, 16'h1); cyc();
    for (int j = 0; j < 8; j++) begin ack(); cyc(); end
    cur_req = "R10"; wr(2'd1, 16'h0); periph_irq = 8'hFF; cyc(2); periph_irq = '0; cyc(2);
    cur_req = "R5"; ack(); cyc();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule